// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block takes a small processor subsystem into a low-power state and brings it back out. Software writes a control word to set a power-down request bit. A fixed entry delay then passes, and the block raises `pd_out`, which switches off the analog circuitry. The processor is expected to halt itself before that delay ends.

Eight general-purpose pins can act as wake sources. Each pin has a 3-bit source code. A wake event clears the request bit and drops `pd_out`. A longer count then lets the oscillator settle, and after it the block raises a wake interrupt that pulls the processor out of its halt. A select bit in the control word decides what drives the processor interrupt line: this wake logic, or the plain external interrupt pin.

Top module: `pwrdn_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until the first write, `pd_out` is 0 and `mpu_irq` equals `ext_int`.
- R2: `pd_out` rises on the ENTRY_CYC-th (32nd) rising clock edge after the edge that captured a write with bit 0 set.
- R3: A write with `wr_en` high loads bit 0 of `wr_data` as the power-down request and bit 1 as the interrupt select (1 = wake logic, 0 = `ext_int`). Writing 1 to bit 2 clears a pending wake interrupt.
- R4: Pin i takes part in wake only when its code `pin_sel[3i+2:3i]` is 4 with the pin high, or 6 with the pin low. The pin is seen two clock edges after it changes. Every other code is ignored.
- R5: A wake condition has effect only while the request bit is set. On the edge that sees it, the request bit and `pd_out` both clear.
- R6: The wake interrupt rises exactly WAKE_CYC (512) edges after the wake edge. It then stays high until an acknowledge write or reset.
- R7: Clearing bit 0 before the entry delay ends aborts entry and `pd_out` stays low. A later request waits the full 32 cycles again.
- R8: A wake during the entry delay cancels entry, and the wake interrupt still follows after the full 512 cycles.
- R9: A new power-down request discards a wake count in progress, and no interrupt is raised from that count.
- R10: With the select at 0, `mpu_irq` follows `ext_int` in the same cycle.
- R11: If software clears the request bit while `pd_out` is high, `pd_out` falls one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 3 | Control word: bit0 request, bit1 select, bit2 acknowledge |
| pin_sel | input | 24 | 3-bit wake source code per pin |
| pin_in | input | 8 | Asynchronous pin levels |
| ext_int | input | 1 | Normal external interrupt path |
| pd_out | output | 1 | Power-down signal to analog functions |
| mpu_irq | output | 1 | Interrupt line to the processor |

## Verification
A wrong entry count shows up as `pd_out` rising one or more cycles off the 32-cycle mark. A reference model compared on every clock catches that within the same cycle. A wake counter left running, or never started, appears at `mpu_irq` only about 512 cycles later. It can also appear as an interrupt that never comes. So every wake scenario runs at least that far, and wake sequences run after a request that should have flushed the counter. A wrong decode of a pin code is first seen when `pd_out` falls three edges after the pin changes. The check for that is made exactly at that edge.

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int NPIN      = 8,
  parameter int SEL_W     = 3,
  parameter int ENTRY_CYC = 32,
  parameter int WAKE_CYC  = 512,
  parameter logic [SEL_W-1:0] SEL_HI = SEL_W'(4),
  parameter logic [SEL_W-1:0] SEL_LO = SEL_W'(6)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_data,
  input  logic [NPIN*SEL_W-1:0] pin_sel,
  input  logic [NPIN-1:0]       pin_in,
  input  logic                  ext_int,
  output logic                  pd_out,
  output logic                  mpu_irq
);
  localparam int EW = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;
  localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [EW-1:0] ENT_LAST = EW'(ENTRY_CYC - 1);
  localparam logic [WW-1:0] WK_LAST  = WW'(WAKE_CYC - 1);

  logic [NPIN-1:0] s1, s2;
  logic            pd_bit, mux_sel, wk_run, wk_irq, wake_any;
  logic [EW-1:0]   ent_cnt;
  logic [WW-1:0]   wk_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end

  always_comb begin
    wake_any = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      if (pin_sel[i*SEL_W +: SEL_W] == SEL_HI &&  s2[i]) wake_any = 1'b1;
      if (pin_sel[i*SEL_W +: SEL_W] == SEL_LO && !s2[i]) wake_any = 1'b1;
    end
  end

  wire hit    = wake_any & pd_bit;
  wire req    = wr_en & wr_data[0];
  wire ack    = wr_en & wr_data[2];
  wire ent_tc = (ent_cnt == ENT_LAST);
  wire wk_tc  = wk_run & (wk_cnt == WK_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_bit  <= 1'b0;
      mux_sel <= 1'b0;
      pd_out  <= 1'b0;
      ent_cnt <= '0;
    end else begin
      if (wr_en) mux_sel <= wr_data[1];
      if (hit) begin
        pd_bit  <= 1'b0;
        pd_out  <= 1'b0;
        ent_cnt <= '0;
      end else begin
        if (wr_en) pd_bit <= wr_data[0];
        pd_out  <= pd_bit & (pd_out | ent_tc);
        ent_cnt <= (!pd_bit || pd_out || ent_tc) ? '0 : ent_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wk_run <= 1'b0;
      wk_cnt <= '0;
      wk_irq <= 1'b0;
    end else begin
      if (wk_tc)    wk_irq <= 1'b1;
      else if (ack) wk_irq <= 1'b0;
      if (hit) begin
        wk_run <= 1'b1;
        wk_cnt <= '0;
      end else if (req || wk_tc) begin
        wk_run <= 1'b0;
        wk_cnt <= '0;
      end else if (wk_run) begin
        wk_cnt <= wk_cnt + 1'b1;
      end
    end

  assign mpu_irq = mux_sel ? wk_irq : ext_int;
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_data,
  input logic       ext_int,
  input logic       pd_out,
  input logic       mpu_irq,
  input logic       pd_bit,
  input logic       wk_run,
  input logic       wk_irq
);
  // R2
  pd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_out) |-> $past(pd_bit));
  // R11
  pd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_bit |=> !pd_out);
  // R5
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wk_run) |-> (!pd_out && !pd_bit));
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wk_irq) |-> $past(wk_run));
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_irq && !(wr_en && wr_data[2])) |=> wk_irq);
  // R10
  mux_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[1]) |=> (mpu_irq == ext_int));
endmodule

bind pwrdn_seq pwrdn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ext_int(ext_int), .pd_out(pd_out), .mpu_irq(mpu_irq),
  .pd_bit(pd_bit), .wk_run(wk_run), .wk_irq(wk_irq)
);

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
  localparam int CLK_PER = 10;
  localparam int NPIN = 8;
  localparam int SW   = 3;
  localparam int ENT  = 32;
  localparam int WK   = 512;

  logic clk = 0, rst_n = 0, wr_en = 0, ext_int = 0;
  logic [2:0] wr_data = '0;
  logic [NPIN*SW-1:0] pin_sel;
  logic [NPIN-1:0] pin_in;
  wire pd_out, mpu_irq;

  pwrdn_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pin_sel(pin_sel), .pin_in(pin_in), .ext_int(ext_int),
    .pd_out(pd_out), .mpu_irq(mpu_irq));

  always #(CLK_PER/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1 reset";

  bit m_pd, m_out, m_run, m_irq, m_mux;
  int m_ent, m_wk;
  logic [NPIN-1:0] p1, p2;

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit wk, hit, fire;
    if (!rst_n) begin
      m_pd = 0; m_out = 0; m_run = 0; m_irq = 0; m_mux = 0;
      m_ent = 0; m_wk = 0; p1 = '0; p2 = '0;
    end else begin
      wk = 0;
      for (int i = 0; i < NPIN; i++) begin
        if (pin_sel[i*SW +: SW] == 3'd4 && p2[i] === 1'b1) wk = 1;
        if (pin_sel[i*SW +: SW] == 3'd6 && p2[i] === 1'b0) wk = 1;
      end
      hit  = wk && m_pd;
      fire = m_run && (m_wk == WK - 1);
      if (fire) m_irq = 1;
      else if (wr_en && wr_data[2]) m_irq = 0;
      if (hit) begin m_run = 1; m_wk = 0; end
      else if ((wr_en && wr_data[0]) || fire) begin m_run = 0; m_wk = 0; end
      else if (m_run) m_wk++;
      if (wr_en) m_mux = wr_data[1];
      if (hit) begin
        m_pd = 0; m_out = 0; m_ent = 0;
      end else begin
        bit reach;
        reach = (m_ent == ENT - 1);
        m_ent = (m_pd && !m_out && !reach) ? m_ent + 1 : 0;
        m_out = m_pd && (m_out || reach);
        if (wr_en) m_pd = wr_data[0];
      end
      p2 = p1; p1 = pin_in;
    end
  end

  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      chk({phase, " pd_out"}, pd_out, m_out);
      chk({phase, " mpu_irq"}, mpu_irq, m_mux ? m_irq : ext_int);
    end
  end

  task automatic wr(logic [2:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pin_sel = '0;
    pin_sel[0*SW +: SW] = 3'd1;
    pin_sel[2*SW +: SW] = 3'd4;
    pin_sel[5*SW +: SW] = 3'd6;
    pin_sel[7*SW +: SW] = 3'd5;
    pin_in = '0;
    pin_in[5] = 1'b1;
    wait_n(2); #1;
    chk("R1 pd_out in reset", pd_out, 1'b0);
    ext_int = 1; #1;
    chk("R1 irq passthrough in reset", mpu_irq, 1'b1);
    ext_int = 0;
    wait_n(1); rst_n = 1;
    wait_n(3); ext_int = 1; wait_n(2); ext_int = 0; wait_n(2);

    phase = "R2 entry delay";
    wr(3'b011);
    wait_n(ENT - 1); #1; chk("R2 pd_out before 32", pd_out, 1'b0);
    wait_n(1);       #1; chk("R2 pd_out at 32", pd_out, 1'b1);

    phase = "R4 ignored codes";
    @(negedge clk); pin_in[0] = 1; pin_in[7] = 1;
    wait_n(5); pin_in[7] = 0; wait_n(5); #1;
    chk("R4 ignored pins keep pd_out", pd_out, 1'b1);
    pin_in[0] = 0;

    phase = "R5 R6 wake high pin";
    @(negedge clk); pin_in[2] = 1;
    wait_n(2); #1; chk("R4 pd_out before sync", pd_out, 1'b1);
    wait_n(1); #1; chk("R5 pd_out cleared by wake", pd_out, 1'b0);
    wait_n(WK - 1); #1; chk("R6 irq before 512", mpu_irq, 1'b0);
    wait_n(1);      #1; chk("R6 irq at 512", mpu_irq, 1'b1);
    pin_in[2] = 0;
    wait_n(20); #1; chk("R6 irq held", mpu_irq, 1'b1);
    phase = "R3 acknowledge";
    wr(3'b110); #1; chk("R3 ack clears irq", mpu_irq, 1'b0);
    wait_n(5);

    phase = "R7 abort";
    wr(3'b011); wait_n(10); wr(3'b010); wait_n(40); #1;
    chk("R7 aborted entry", pd_out, 1'b0);
    wr(3'b011);
    wait_n(ENT - 1); #1; chk("R7 restart before 32", pd_out, 1'b0);
    wait_n(1);       #1; chk("R7 restart at 32", pd_out, 1'b1);

    phase = "R11 software clear";
    wr(3'b010); #1; chk("R11 pd_out one edge later", pd_out, 1'b1);
    wait_n(1); #1;  chk("R11 pd_out dropped", pd_out, 1'b0);

    phase = "R8 wake during entry";
    wr(3'b011); wait_n(10);
    @(negedge clk); pin_in[5] = 0;
    wait_n(3); #1; chk("R8 entry cancelled", pd_out, 1'b0);
    wait_n(WK - 1); #1; chk("R8 irq before 512", mpu_irq, 1'b0);
    wait_n(1);      #1; chk("R8 irq at 512", mpu_irq, 1'b1);
    wait_n(40); #1; chk("R8 pd_out stayed low", pd_out, 1'b0);
    pin_in[5] = 1;
    wr(3'b110); wait_n(5);

    phase = "R9 flush wake count";
    wr(3'b011); wait_n(40);
    @(negedge clk); pin_in[2] = 1;
    wait_n(4); pin_in[2] = 0;
    wait_n(100); wr(3'b011);
    wait_n(600); #1; chk("R9 no stale irq", mpu_irq, 1'b0);
    chk("R9 re-entered power-down", pd_out, 1'b1);
    wr(3'b010); wait_n(5);

    phase = "R10 external path";
    wr(3'b000);
    ext_int = 1; #1; chk("R10 irq follows ext_int high", mpu_irq, 1'b1);
    wait_n(3); ext_int = 0; #1; chk("R10 irq follows ext_int low", mpu_irq, 1'b0);
    wait_n(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule